// File: doc/BRIEF.md
# DMA Channel Enable Sequencer

This block owns the run state of one DMA channel. Software programs a transfer mode, a request source, a total transfer count and a unit (block or cluster) length through a single write port; the same write sets or clears the channel enable bit. While enabled, the block issues one transfer at a time. It raises a strobe when a transfer may start and waits for that transfer's acknowledge before it issues the next one. Each acknowledge counts against the total and against the position inside the current unit.

The enable bit drops for one of several reasons, and the block reports which one. Reaching the total count ends the channel. A software clear in single-unit mode takes effect at once, but in block or cluster mode it waits for the running unit to finish. Several halt and fault inputs end the transfer at once, and a standby input forces the bit low. Each clear produces a one-cycle end pulse and latches a 3-bit cause code. That code holds until the next clear. Address generation, the bus cycle itself and interrupt routing are done by neighbouring logic.

Top module: `dmaen_ctrl`

## Requirements
- R1: After reset, `chan_enable`, `xfer_issue`, `end_pulse` are 0 and `end_cause` is 3'd0.
- R2: With request source auto (`cfg_ext_src`=0), a write with `cfg_enable`=1 starts the channel. `xfer_issue` is 1 in the cycle right after the write. After that it is 1 again once the previous transfer is acknowledged, and never in two consecutive cycles.
- R3: With request source external (`cfg_ext_src`=1), enabling the channel only arms it. No transfer is issued without `ext_req`. When the channel is enabled and idle, an `ext_req` raises `xfer_issue` in the same cycle.
- R4: In external mode, a request that arrives while a transfer awaits its acknowledge is held in one pending flag. That request is issued after the acknowledge. Further requests during the same wait are dropped.
- R5: When the acknowledge of the last of `cfg_total` transfers arrives, `chan_enable` is 0 in the next cycle and `end_pulse` is 1 with cause 3'd1.
- R6: In normal mode (`cfg_mode`=2'b00), a write of `cfg_enable`=0 clears the channel in the next cycle with cause 3'd2. An acknowledge that arrives later starts nothing.
- R7: In block (2'b01) or cluster (2'b10) mode, a write of 0 while a unit of `cfg_unit` transfers is in progress leaves `chan_enable` at 1. Transfers continue to the end of that unit, and the channel then clears with cause 3'd2.
- R8: While enabled, each of these inputs clears the channel in the next cycle and stops further issues: `halt_rpt_end` (cause 3'd3), `halt_area_ovf` (3'd4), `halt_size_err` (3'd5), `ext_abort` (3'd6), and `addr_err` or `nmi` (3'd7). While disabled these inputs are ignored.
- R9: Cause priority, highest first: standby, fault (3'd7), 3'd6, 3'd5, 3'd4, 3'd3, total (3'd1), software (3'd2). An immediate halt in the same cycle as the final acknowledge therefore reports the halt code.
- R10: `standby` clears an enabled channel with cause 3'd0. When the channel is already disabled it gives no end pulse.
- R11: A write made while the channel is enabled does not change mode, request source, total or unit length.
- R12: `end_pulse` lasts exactly one cycle, and `end_cause` holds its value until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control fields |
| cfg_enable | input | 1 | Enable value written |
| cfg_mode | input | 2 | 00 normal, 01 block, 10 cluster |
| cfg_ext_src | input | 1 | 0 auto request, 1 external request |
| cfg_total | input | TOTAL_W | Total number of transfers (nonzero) |
| cfg_unit | input | UNIT_W | Transfers per block or cluster (nonzero) |
| ext_req | input | 1 | External transfer request |
| xfer_ack | input | 1 | Acknowledge of the outstanding transfer |
| halt_rpt_end | input | 1 | Halt at repeat-size end |
| halt_area_ovf | input | 1 | Halt on extended repeat area overflow |
| halt_size_err | input | 1 | Transfer size error |
| ext_abort | input | 1 | External abort request |
| addr_err | input | 1 | Address error |
| nmi | input | 1 | Non-maskable interrupt |
| standby | input | 1 | Standby entry, forces enable low |
| xfer_issue | output | 1 | Strobe: start one transfer |
| chan_enable | output | 1 | Readable enable/active bit |
| end_pulse | output | 1 | One-cycle end-of-transfer pulse |
| end_cause | output | 3 | Latched cause of the last clear |

## Verification
The assertions assume that `cfg_total` and `cfg_unit` are nonzero when a channel is started. They also assume that `xfer_ack` is raised only while a transfer is outstanding, so the unit position always stays below the unit length. The bench programs only nonzero sizes of at most 20 transfers and unit lengths from 1 to 4. Its acknowledge responder answers only an observed issue strobe, after a fixed delay of one to three cycles. Manual acknowledges are given only right after an issue.

// File: rtl/dmaen_pkg.sv
// Package dmaen_pkg
// Shared encodings for the DMA channel enable sequencer: transfer modes
// and the end-cause codes. Assumes a 3-bit cause field decoded by software.
package dmaen_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_BLOCK   = 2'b01,
        MODE_CLUSTER = 2'b10,
        MODE_RSVD    = 2'b11
    } xfer_mode_t;

    typedef enum logic [2:0] {
        CAUSE_STANDBY   = 3'd0,
        CAUSE_TOTAL     = 3'd1,
        CAUSE_SOFT      = 3'd2,
        CAUSE_RPT_END   = 3'd3,
        CAUSE_AREA_OVF  = 3'd4,
        CAUSE_SIZE_ERR  = 3'd5,
        CAUSE_EXT_ABORT = 3'd6,
        CAUSE_FAULT     = 3'd7
    } end_cause_t;

    // Immediate halt inputs, lowest priority first; code = HALT_BASE + index
    localparam int NUM_HALT  = 5;
    localparam int HALT_BASE = 3;

endpackage

// File: rtl/dmaen_count.sv
// Module dmaen_count
// Tracks transfers left against the programmed total and the position inside
// the current block or cluster. Assumes total and unit length are nonzero at
// load and that step is only raised for an accepted acknowledge.
module dmaen_count #(
    parameter int TOTAL_W = 8,
    parameter int UNIT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TOTAL_W-1:0] total_in,
    input  logic [UNIT_W-1:0]  unit_in,
    input  logic               step,
    output logic               last_xfer,
    output logic               unit_last,
    output logic               unit_mid
);

    logic [TOTAL_W-1:0] left_q;
    logic [UNIT_W-1:0]  unit_q;
    logic [UNIT_W-1:0]  pos_q;

    assign last_xfer = (left_q == TOTAL_W'(1));
    assign unit_last = (pos_q == unit_q - 1'b1);
    assign unit_mid  = (pos_q != '0);

    // Load sizes at start, count down the total and wrap the unit position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            unit_q <= '0;
            pos_q  <= '0;
        end else if (load) begin
            left_q <= total_in;
            unit_q <= unit_in;
            pos_q  <= '0;
        end else if (step) begin
            left_q <= left_q - 1'b1;
            pos_q  <= unit_last ? '0 : pos_q + 1'b1;
        end
    end

    AST_POS_BELOW_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_q != '0) |-> (pos_q < unit_q)); // R7

endmodule

// File: rtl/dmaen_trig.sv
// Module dmaen_trig
// Decides whether a transfer may be issued this cycle. Auto source fires
// whenever ready; external source needs a live request or the single pending
// flag. Assumes ready already excludes an outstanding transfer.
module dmaen_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic flush,
    input  logic src_ext,
    input  logic ready,
    input  logic ext_req,
    output logic fire
);

    logic pend_q;

    assign fire = ready && (!src_ext || pend_q || ext_req);

    // Hold one request that arrives while the channel cannot issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!enable || flush) begin
            pend_q <= 1'b0;
        end else if (fire && src_ext) begin
            pend_q <= pend_q && ext_req;
        end else if (src_ext && ext_req) begin
            pend_q <= 1'b1;
        end
    end

    AST_PEND_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> src_ext); // R4

endmodule

// File: rtl/dmaen_halt.sv
// Module dmaen_halt
// Priority arbiter for every reason the enable bit may drop. Produces the
// clear decision and its cause code. Only an enabled channel can be cleared.
module dmaen_halt
    import dmaen_pkg::*;
(
    input  logic                enable,
    input  logic                standby,
    input  logic [NUM_HALT-1:0] halt_vec,
    input  logic                total_done,
    input  logic                soft_done,
    output logic                clear,
    output end_cause_t          cause
);

    logic any_req;

    // Later assignments override earlier ones, giving the priority order
    always_comb begin
        any_req = 1'b0;
        cause   = CAUSE_SOFT;
        if (soft_done) begin
            any_req = 1'b1;
            cause   = CAUSE_SOFT;
        end
        if (total_done) begin
            any_req = 1'b1;
            cause   = CAUSE_TOTAL;
        end
        for (int i = 0; i < NUM_HALT; i++) begin
            if (halt_vec[i]) begin
                any_req = 1'b1;
                cause   = end_cause_t'(3'(HALT_BASE + i));
            end
        end
        if (standby) begin
            any_req = 1'b1;
            cause   = CAUSE_STANDBY;
        end
        clear = any_req && enable;
    end

endmodule

// File: rtl/dmaen_ctrl.sv
// Module dmaen_ctrl
// Enable sequencer of one DMA channel: holds the configuration, the enable
// bit and the outstanding-transfer flag, defers software clears in block and
// cluster modes, and reports each clear with a pulse and a cause code.
// Assumes xfer_ack only comes for an issued transfer.
module dmaen_ctrl
    import dmaen_pkg::*;
#(
    parameter int TOTAL_W = 8,
    parameter int UNIT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic               cfg_enable,
    input  logic [1:0]         cfg_mode,
    input  logic               cfg_ext_src,
    input  logic [TOTAL_W-1:0] cfg_total,
    input  logic [UNIT_W-1:0]  cfg_unit,
    input  logic               ext_req,
    input  logic               xfer_ack,
    input  logic               halt_rpt_end,
    input  logic               halt_area_ovf,
    input  logic               halt_size_err,
    input  logic               ext_abort,
    input  logic               addr_err,
    input  logic               nmi,
    input  logic               standby,
    output logic               xfer_issue,
    output logic               chan_enable,
    output logic               end_pulse,
    output logic [2:0]         end_cause
);

    logic       en_q, busy_q, stop_q, src_q, endp_q;
    xfer_mode_t mode_q;
    end_cause_t cause_q, clear_cause;
    logic       cfg_load, wr_off, ack_ok, unit_mode, in_unit;
    logic       last_xfer, unit_last, unit_mid;
    logic       soft_done, total_done, clear_now, ready;
    logic [NUM_HALT-1:0] halt_vec;

    assign cfg_load   = cfg_wr && !en_q;
    assign wr_off     = cfg_wr && !cfg_enable && en_q;
    assign ack_ok     = en_q && busy_q && xfer_ack;
    assign unit_mode  = (mode_q == MODE_BLOCK) || (mode_q == MODE_CLUSTER);
    assign in_unit    = busy_q || unit_mid;
    assign soft_done  = unit_mode
                      ? ((wr_off && !in_unit) || ((stop_q || wr_off) && ack_ok && unit_last))
                      : wr_off;
    assign total_done = ack_ok && last_xfer;
    assign ready      = en_q && !busy_q && !clear_now;
    assign halt_vec   = {addr_err || nmi, ext_abort, halt_size_err, halt_area_ovf, halt_rpt_end};

    dmaen_count #(.TOTAL_W(TOTAL_W), .UNIT_W(UNIT_W)) i_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .total_in  (cfg_total),
        .unit_in   (cfg_unit),
        .step      (ack_ok),
        .last_xfer (last_xfer),
        .unit_last (unit_last),
        .unit_mid  (unit_mid)
    );

    dmaen_trig i_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (en_q),
        .flush   (clear_now),
        .src_ext (src_q),
        .ready   (ready),
        .ext_req (ext_req),
        .fire    (xfer_issue)
    );

    dmaen_halt i_halt (
        .enable     (en_q),
        .standby    (standby),
        .halt_vec   (halt_vec),
        .total_done (total_done),
        .soft_done  (soft_done),
        .clear      (clear_now),
        .cause      (clear_cause)
    );

    // Configuration latches only while the channel is disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
            src_q  <= 1'b0;
        end else if (cfg_load) begin
            mode_q <= xfer_mode_t'(cfg_mode);
            src_q  <= cfg_ext_src;
        end
    end

    // Enable bit, outstanding-transfer flag and deferred software stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            busy_q <= 1'b0;
            stop_q <= 1'b0;
        end else if (clear_now) begin
            en_q   <= 1'b0;
            busy_q <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            if (cfg_load) en_q <= cfg_enable && !standby;
            if (xfer_issue)  busy_q <= 1'b1;
            else if (ack_ok) busy_q <= 1'b0;
            if (wr_off && unit_mode && in_unit) stop_q <= 1'b1;
        end
    end

    // End pulse and latched cause of the most recent clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            endp_q  <= 1'b0;
            cause_q <= CAUSE_STANDBY;
        end else begin
            endp_q <= clear_now;
            if (clear_now) cause_q <= clear_cause;
        end
    end

    assign chan_enable = en_q;
    assign end_pulse   = endp_q;
    assign end_cause   = cause_q;

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_issue |=> !xfer_issue); // R2
    AST_END_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> !chan_enable); // R5
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> !end_pulse); // R12
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_q) |-> ($stable(mode_q) && $stable(src_q))); // R11
    AST_DEFER_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_off && unit_mode && in_unit && !clear_now) |=> chan_enable); // R7

endmodule

// File: tb/test_dmaen_ctrl.sv
// Bench for dmaen_ctrl: sweeps totals, ack delays, unit lengths, stop points
// and every halt input, computing expected counts and causes arithmetically.
module test_dmaen_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_enable = 1'b0, cfg_ext_src = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [7:0] cfg_total = 8'd0;
    logic [3:0] cfg_unit = 4'd0;
    logic       ext_req = 1'b0, ack_auto = 1'b0, ack_man = 1'b0, xfer_ack;
    logic       halt_rpt_end = 0, halt_area_ovf = 0, halt_size_err = 0;
    logic       ext_abort = 0, addr_err = 0, nmi = 0, standby = 0;
    logic       xfer_issue, chan_enable, end_pulse;
    logic [2:0] end_cause;

    int checks = 0, failures = 0;
    int n_issue = 0, n_end = 0;
    int ack_dly = 0;
    int dcnt = 0;

    assign xfer_ack = ack_auto | ack_man;

    always #2 clk = ~clk;

    dmaen_ctrl #(.TOTAL_W(8), .UNIT_W(4)) i_dmaen_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
        .cfg_mode(cfg_mode), .cfg_ext_src(cfg_ext_src), .cfg_total(cfg_total),
        .cfg_unit(cfg_unit), .ext_req(ext_req), .xfer_ack(xfer_ack),
        .halt_rpt_end(halt_rpt_end), .halt_area_ovf(halt_area_ovf),
        .halt_size_err(halt_size_err), .ext_abort(ext_abort), .addr_err(addr_err),
        .nmi(nmi), .standby(standby), .xfer_issue(xfer_issue),
        .chan_enable(chan_enable), .end_pulse(end_pulse), .end_cause(end_cause)
    );

    // Acknowledge responder and event counters
    always @(posedge clk) begin
        if (!rst_n) begin
            dcnt <= 0; ack_auto <= 1'b0; n_issue <= 0; n_end <= 0;
        end else begin
            if (xfer_issue) n_issue <= n_issue + 1;
            if (end_pulse)  n_end <= n_end + 1;
            if (xfer_issue && ack_dly != 0) dcnt <= ack_dly;
            else if (dcnt != 0) dcnt <= dcnt - 1;
            ack_auto <= (dcnt == 1);
        end
    end

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic cfg(logic en, logic [1:0] md, logic src, int tot, int un);
        cfg_enable = en; cfg_mode = md; cfg_ext_src = src;
        cfg_total = 8'(tot); cfg_unit = 4'(un); cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic wait_end(int maxc);
        int e0 = n_end;
        for (int i = 0; i < maxc && n_end == e0; i++) tick();
    endtask

    task automatic set_halt(int idx, logic v);
        case (idx)
            0: halt_rpt_end = v;
            1: halt_area_ovf = v;
            2: halt_size_err = v;
            3: ext_abort = v;
            4: addr_err = v;
            5: nmi = v;
            default: standby = v;
        endcase
    endtask

    function automatic int halt_code(int idx);
        case (idx)
            0: return 3;
            1: return 4;
            2: return 5;
            3: return 6;
            4, 5: return 7;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        int base, e0, c0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        check_eq("R1 enable", chan_enable, 0);
        check_eq("R1 issue", xfer_issue, 0);
        check_eq("R1 end_pulse", end_pulse, 0);
        check_eq("R1 cause", end_cause, 0);

        // R2/R5: auto request, totals 1..5, ack delays 1..3
        for (int tot = 1; tot <= 5; tot++) begin
            for (int d = 1; d <= 3; d++) begin
                ack_dly = d;
                base = n_issue; e0 = n_end;
                cfg(1, 2'b00, 0, tot, 1);
                check_eq("R2 first issue after write", xfer_issue, 1);
                wait_end(200);
                check_eq("R5 issue count", n_issue - base, tot);
                check_eq("R5 end count", n_end - e0, 1);
                check_eq("R5 cause", end_cause, 1);
                check_eq("R5 enable low", chan_enable, 0);
                repeat (4) tick();
            end
        end

        // R3/R4: external request with pending flag
        ack_dly = 2;
        base = n_issue;
        cfg(1, 2'b00, 1, 3, 1);
        repeat (6) tick();
        check_eq("R3 no issue without request", n_issue - base, 0);
        ext_req = 1'b1; #1;
        check_eq("R3 same-cycle issue", xfer_issue, 1);
        tick(); tick(); tick();
        ext_req = 1'b0;
        repeat (8) tick();
        check_eq("R4 one pending kept, extra dropped", n_issue - base, 2);
        check_eq("R4 still enabled", chan_enable, 1);
        ext_req = 1'b1; tick(); ext_req = 1'b0;
        wait_end(50);
        check_eq("R4 final count", n_issue - base, 3);
        check_eq("R4 final cause", end_cause, 1);
        repeat (4) tick();

        // R6: normal-mode software clear is immediate
        ack_dly = 0;
        base = n_issue;
        cfg(1, 2'b00, 0, 10, 1);
        tick();
        cfg(0, 2'b00, 0, 10, 1);
        check_eq("R6 enable low", chan_enable, 0);
        check_eq("R6 end pulse", end_pulse, 1);
        check_eq("R6 cause", end_cause, 2);
        ack_man = 1'b1; tick(); ack_man = 1'b0;
        repeat (5) tick();
        check_eq("R6 no issue after late ack", n_issue - base, 1);

        // R7: block and cluster deferral, all units 1..4 and stop points
        ack_dly = 1;
        for (int m = 1; m <= 2; m++) begin
            for (int u = 1; u <= 4; u++) begin
                for (int k = 1; k <= u; k++) begin
                    base = n_issue;
                    cfg(1, 2'(m), 0, 15, u);
                    for (int i = 0; i < 60 && (n_issue - base) < k; i++) tick();
                    cfg(0, 2'(m), 0, 15, u);
                    check_eq("R7 enable held during unit", chan_enable, 1);
                    wait_end(60);
                    check_eq("R7 unit completed", n_issue - base, u);
                    check_eq("R7 cause", end_cause, 2);
                    repeat (3) tick();
                end
            end
        end

        // R8/R10/R12: every halt input while enabled
        ack_dly = 2;
        for (int h = 0; h < 7; h++) begin
            cfg(1, 2'b00, 0, 20, 1);
            repeat (3) tick();
            set_halt(h, 1'b1); tick(); set_halt(h, 1'b0);
            check_eq("R8 enable low after halt", chan_enable, 0);
            check_eq("R8 end pulse", end_pulse, 1);
            check_eq("R8 halt cause", end_cause, halt_code(h));
            base = n_issue;
            repeat (6) tick();
            check_eq("R8 no issue after halt", n_issue - base, 0);
            check_eq("R12 pulse single", end_pulse, 0);
            check_eq("R12 cause held", end_cause, halt_code(h));
        end

        // R8/R10: inputs ignored while disabled
        e0 = n_end; c0 = end_cause;
        ext_abort = 1'b1; tick(); ext_abort = 1'b0;
        standby = 1'b1; tick(); standby = 1'b0;
        repeat (3) tick();
        check_eq("R10 no pulse while disabled", n_end - e0, 0);
        check_eq("R8 cause unchanged while disabled", end_cause, c0);

        // R9: priority
        cfg(1, 2'b00, 0, 20, 1);
        tick();
        nmi = 1'b1; halt_size_err = 1'b1; tick(); nmi = 1'b0; halt_size_err = 1'b0;
        check_eq("R9 fault over size error", end_cause, 7);
        repeat (4) tick();
        cfg(1, 2'b00, 0, 20, 1);
        tick();
        halt_rpt_end = 1'b1; halt_size_err = 1'b1; ext_abort = 1'b1; tick();
        halt_rpt_end = 1'b0; halt_size_err = 1'b0; ext_abort = 1'b0;
        check_eq("R9 abort over lower halts", end_cause, 6);
        repeat (4) tick();
        cfg(1, 2'b00, 0, 20, 1);
        tick();
        standby = 1'b1; nmi = 1'b1; tick(); standby = 1'b0; nmi = 1'b0;
        check_eq("R9 standby highest", end_cause, 0);
        repeat (4) tick();
        ack_dly = 0;
        cfg(1, 2'b00, 0, 1, 1);
        tick();
        ack_man = 1'b1; halt_rpt_end = 1'b1; tick(); ack_man = 1'b0; halt_rpt_end = 1'b0;
        check_eq("R9 halt over size complete", end_cause, 3);
        check_eq("R9 enable low", chan_enable, 0);
        repeat (4) tick();

        // R11: configuration frozen while enabled
        ack_dly = 1;
        base = n_issue;
        cfg(1, 2'b00, 0, 3, 1);
        tick();
        cfg(1, 2'b01, 1, 1, 1);
        wait_end(60);
        check_eq("R11 total unchanged", n_issue - base, 3);
        check_eq("R11 cause", end_cause, 1);

        report();
        $finish;
    end

endmodule